// File: doc/BRIEF.md
# MSI Private Cache Line Controller

This block holds the coherence state of the lines in one core's private data cache and runs a three-state protocol (Invalid, Shared, Modified) on them. It takes two streams of events. Local events (load, store, evict) arrive from the core. Remote events (invalidate, read probe, exclusive probe) arrive from the shared directory. For each event it updates the line state and decides what goes out. That can be a fetch or upgrade request to the shared level, a write-back or clean notice, or an acknowledgement of the remote event, flagged when dirty data has to go back.

The state array is direct-mapped. The low log2(NUM_LINES) bits of a line address select the entry, and the remaining bits form the tag. Only one local miss is outstanding at a time. Remote events always take precedence over local work in the same cycle. A store to a line that another core holds Modified is resolved by the directory. The directory sends that core an exclusive probe, which answers with a write-back acknowledgement. Only after that does this block receive the grant that lets its store complete.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, lreq_ready_o is 1, and lrsp_valid_o, sreq_valid_o and ack_valid_o are 0.
- R2: Local op codes are load 0, store 1 and evict 2. A load hits when the tag matches and the line is Shared or Modified. A store hits only when the line is Modified. A hit raises lrsp_valid_o with lrsp_hit_o=1 in the cycle after acceptance and sends nothing to the shared level.
- R3: Shared-level request codes are GETS 0, GETM 1, PUTM 2 and PUTS 3. A load miss sends GETS for the request address, and a store miss or a store to a Shared line sends GETM. The grant installs Shared for a GETS and Modified for a GETM. In the cycle after the grant, lrsp_valid_o=1 with lrsp_hit_o=0.
- R4: A miss whose entry holds a valid line with a different tag first sends that victim out. The victim goes as PUTM if Modified and PUTS if Shared, carrying the victim's address, before the GETS or GETM.
- R5: A local evict of a Modified line sends PUTM, and of a Shared line sends PUTS. The line then becomes Invalid, and a later load to it misses. Evicting an absent line completes with lrsp_hit_o=0 and no shared-level message.
- R6: Remote codes are invalidate 0, read probe 1 and exclusive probe 2. Invalidate and exclusive probe take a present line to Invalid, and a read probe takes a present line to Shared. The cycle after any remote event, ack_valid_o=1 with ack_addr_o equal to the event address and ack_wb_o=1 exactly when the line was Modified.
- R7: A remote event to a line not present is acknowledged with ack_wb_o=0 and changes no line.
- R8: From acceptance of a missing load or store until its grant, lreq_ready_o stays 0.
- R9: In any cycle with fwd_valid_i=1, lreq_ready_o and sreq_valid_o are both 0.
- R10: A remote event to a line whose upgrade is pending acts on the line's current stable state. The later grant still installs the requested state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lreq_valid_i | input | 1 | Local event present |
| lreq_ready_o | output | 1 | Local event accepted this cycle |
| lreq_op_i | input | 2 | Local op: load 0, store 1, evict 2 |
| lreq_addr_i | input | ADDR_W | Local line address |
| lrsp_valid_o | output | 1 | Local event completed |
| lrsp_hit_o | output | 1 | Completed without a fetch |
| sreq_valid_o | output | 1 | Request to shared level present |
| sreq_ready_i | input | 1 | Shared level takes the request |
| sreq_type_o | output | 2 | GETS 0, GETM 1, PUTM 2, PUTS 3 |
| sreq_addr_o | output | ADDR_W | Request line address |
| sgnt_valid_i | input | 1 | Grant for the outstanding fetch |
| fwd_valid_i | input | 1 | Remote event present |
| fwd_type_i | input | 2 | Invalidate 0, read probe 1, exclusive probe 2 |
| fwd_addr_i | input | ADDR_W | Remote event line address |
| ack_valid_o | output | 1 | Acknowledgement of a remote event |
| ack_wb_o | output | 1 | Acknowledgement carries dirty data |
| ack_addr_o | output | ADDR_W | Acknowledged line address |

## Verification
Every cycle, the checker enforces that remote events block local acceptance and outgoing requests, that every remote event gets exactly one acknowledgement carrying its address in the following cycle, that hits answer one cycle after acceptance, and that no local event is taken while a fetch is being presented. Which state a line ends up in can only be shown by the scenarios: a later hit or miss, or the write-back flag of a later acknowledgement, reveals it. The bench's scenarios also cover victim ordering, eviction notices and the invalidation that races a pending upgrade.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_M = 2'd2
  } line_st_e;

  localparam logic [1:0] LOP_LOAD  = 2'd0;
  localparam logic [1:0] LOP_STORE = 2'd1;
  localparam logic [1:0] LOP_EVICT = 2'd2;

  localparam logic [1:0] SQ_GETS = 2'd0;
  localparam logic [1:0] SQ_GETM = 2'd1;
  localparam logic [1:0] SQ_PUTM = 2'd2;
  localparam logic [1:0] SQ_PUTS = 2'd3;

  localparam logic [1:0] FW_INV = 2'd0;
  localparam logic [1:0] FW_RD  = 2'd1;
  localparam logic [1:0] FW_EX  = 2'd2;

  typedef enum logic [2:0] {
    C_IDLE  = 3'd0,
    C_VICT  = 3'd1,
    C_GET   = 3'd2,
    C_WAIT  = 3'd3,
    C_EVICT = 3'd4
  } ctl_e;
endpackage

// File: rtl/msi_tag_array.sv
module msi_tag_array #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 6,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] la_idx_i,
  output logic [TAG_W-1:0] la_tag_o,
  output logic [1:0]       la_st_o,
  input  logic [IDX_W-1:0] fa_idx_i,
  output logic [TAG_W-1:0] fa_tag_o,
  output logic [1:0]       fa_st_o,
  input  logic             fw_en_i,
  input  logic [IDX_W-1:0] fw_idx_i,
  input  logic [1:0]       fw_st_i,
  input  logic             cw_en_i,
  input  logic [IDX_W-1:0] cw_idx_i,
  input  logic [TAG_W-1:0] cw_tag_i,
  input  logic [1:0]       cw_st_i
);
  logic [NUM_LINES-1:0][TAG_W-1:0] tag_all;
  logic [NUM_LINES-1:0][1:0]       st_all;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_ent
    logic [TAG_W-1:0] tag_q;
    logic [1:0]       st_q;
    logic             cw_hit, fw_hit;
    assign cw_hit = cw_en_i && (cw_idx_i == IDX_W'(g));
    assign fw_hit = fw_en_i && (fw_idx_i == IDX_W'(g));
    // controller write (grant, victim, evict) wins over a same-cycle remote update
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q <= '0;
        st_q  <= msi_pkg::LN_I;
      end else if (cw_hit) begin
        tag_q <= cw_tag_i;
        st_q  <= cw_st_i;
      end else if (fw_hit) begin
        st_q  <= fw_st_i;
      end
    end
    assign tag_all[g] = tag_q;
    assign st_all[g]  = st_q;
  end

  assign la_tag_o = tag_all[la_idx_i];
  assign la_st_o  = st_all[la_idx_i];
  assign fa_tag_o = tag_all[fa_idx_i];
  assign fa_st_o  = st_all[fa_idx_i];
endmodule

// File: rtl/msi_fwd_resolve.sv
module msi_fwd_resolve (
  input  logic [1:0] st_i,
  input  logic [1:0] kind_i,
  input  logic       present_i,
  output logic [1:0] nxt_o,
  output logic       wb_o
);
  import msi_pkg::*;
  always_comb begin
    wb_o  = present_i && (st_i == LN_M);
    nxt_o = st_i;
    if (present_i) begin
      // read probe keeps a readable copy; everything else drops it
      nxt_o = (kind_i == FW_RD) ? LN_S : LN_I;
    end
  end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl #(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lreq_valid_i,
  output logic              lreq_ready_o,
  input  logic [1:0]        lreq_op_i,
  input  logic [ADDR_W-1:0] lreq_addr_i,
  output logic              lrsp_valid_o,
  output logic              lrsp_hit_o,
  output logic              sreq_valid_o,
  input  logic              sreq_ready_i,
  output logic [1:0]        sreq_type_o,
  output logic [ADDR_W-1:0] sreq_addr_o,
  input  logic              sgnt_valid_i,
  input  logic              fwd_valid_i,
  input  logic [1:0]        fwd_type_i,
  input  logic [ADDR_W-1:0] fwd_addr_i,
  output logic              ack_valid_o,
  output logic              ack_wb_o,
  output logic [ADDR_W-1:0] ack_addr_o
);
  import msi_pkg::*;

  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_e              ctl_q, ctl_d;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rsp_v_d, rsp_hit_d;

  logic [IDX_W-1:0]  l_idx, f_idx;
  logic [TAG_W-1:0]  l_tag, f_tag, la_tag, fa_tag, req_tag;
  logic [1:0]        la_st, fa_st, f_nxt;
  logic              l_match, l_valid, f_present, f_wb, accept, hs, want;

  logic              cw_en;
  logic [TAG_W-1:0]  cw_tag;
  logic [1:0]        cw_st;

  // lookup ports
  assign l_idx   = (ctl_q == C_IDLE) ? lreq_addr_i[IDX_W-1:0] : addr_q[IDX_W-1:0];
  assign l_tag   = (ctl_q == C_IDLE) ? lreq_addr_i[ADDR_W-1:IDX_W] : addr_q[ADDR_W-1:IDX_W];
  assign req_tag = addr_q[ADDR_W-1:IDX_W];
  assign f_idx   = fwd_addr_i[IDX_W-1:0];
  assign f_tag   = fwd_addr_i[ADDR_W-1:IDX_W];

  msi_tag_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_arr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .la_idx_i (l_idx),
    .la_tag_o (la_tag),
    .la_st_o  (la_st),
    .fa_idx_i (f_idx),
    .fa_tag_o (fa_tag),
    .fa_st_o  (fa_st),
    .fw_en_i  (fwd_valid_i && f_present),
    .fw_idx_i (f_idx),
    .fw_st_i  (f_nxt),
    .cw_en_i  (cw_en),
    .cw_idx_i (l_idx),
    .cw_tag_i (cw_tag),
    .cw_st_i  (cw_st)
  );

  assign l_match   = (la_tag == l_tag);
  assign l_valid   = (la_st != LN_I);
  assign f_present = (fa_tag == f_tag) && (fa_st != LN_I);

  msi_fwd_resolve u_fwd (
    .st_i      (fa_st),
    .kind_i    (fwd_type_i),
    .present_i (f_present),
    .nxt_o     (f_nxt),
    .wb_o      (f_wb)
  );

  // remote events take the cycle
  assign lreq_ready_o = (ctl_q == C_IDLE) && !fwd_valid_i;
  assign accept       = lreq_valid_i && lreq_ready_o;

  always_comb begin
    want        = 1'b0;
    sreq_type_o = SQ_GETS;
    sreq_addr_o = addr_q;
    unique case (ctl_q)
      C_VICT, C_EVICT: begin
        want        = l_valid;
        sreq_type_o = (la_st == LN_M) ? SQ_PUTM : SQ_PUTS;
        sreq_addr_o = {la_tag, l_idx};
      end
      C_GET: begin
        want        = 1'b1;
        sreq_type_o = (op_q == LOP_STORE) ? SQ_GETM : SQ_GETS;
      end
      default: ;
    endcase
  end

  assign sreq_valid_o = want && !fwd_valid_i;
  assign hs           = sreq_valid_o && sreq_ready_i;

  always_comb begin
    ctl_d     = ctl_q;
    rsp_v_d   = 1'b0;
    rsp_hit_d = 1'b0;
    cw_en     = 1'b0;
    cw_tag    = la_tag;
    cw_st     = la_st;
    unique case (ctl_q)
      C_IDLE: if (accept) begin
        unique case (lreq_op_i)
          LOP_LOAD, LOP_STORE: begin
            if (l_match && ((lreq_op_i == LOP_LOAD) ? l_valid : (la_st == LN_M))) begin
              rsp_v_d   = 1'b1;
              rsp_hit_d = 1'b1;
            end else if (!l_match && l_valid) begin
              ctl_d = C_VICT;
            end else begin
              ctl_d = C_GET;
            end
          end
          LOP_EVICT: begin
            if (l_match && l_valid) ctl_d = C_EVICT;
            else rsp_v_d = 1'b1;
          end
          default: rsp_v_d = 1'b1;
        endcase
      end
      C_VICT: begin
        if (!l_valid) begin
          ctl_d = C_GET;
        end else if (hs) begin
          cw_en = 1'b1;
          cw_st = LN_I;
          ctl_d = C_GET;
        end
      end
      C_GET: if (hs) begin
        cw_en  = 1'b1;
        cw_tag = req_tag;
        cw_st  = l_match ? la_st : LN_I;
        ctl_d  = C_WAIT;
      end
      C_WAIT: if (sgnt_valid_i) begin
        cw_en   = 1'b1;
        cw_tag  = req_tag;
        cw_st   = (op_q == LOP_STORE) ? LN_M : LN_S;
        rsp_v_d = 1'b1;
        ctl_d   = C_IDLE;
      end
      C_EVICT: begin
        if (!l_valid) begin
          rsp_v_d = 1'b1;
          ctl_d   = C_IDLE;
        end else if (hs) begin
          cw_en   = 1'b1;
          cw_st   = LN_I;
          rsp_v_d = 1'b1;
          ctl_d   = C_IDLE;
        end
      end
      default: ctl_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q        <= C_IDLE;
      op_q         <= LOP_LOAD;
      addr_q       <= '0;
      lrsp_valid_o <= 1'b0;
      lrsp_hit_o   <= 1'b0;
      ack_valid_o  <= 1'b0;
      ack_wb_o     <= 1'b0;
      ack_addr_o   <= '0;
    end else begin
      ctl_q        <= ctl_d;
      lrsp_valid_o <= rsp_v_d;
      lrsp_hit_o   <= rsp_hit_d;
      ack_valid_o  <= fwd_valid_i;
      ack_wb_o     <= fwd_valid_i && f_wb;
      if (fwd_valid_i) ack_addr_o <= fwd_addr_i;
      if (accept) begin
        op_q   <= lreq_op_i;
        addr_q <= lreq_addr_i;
      end
    end
  end
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lreq_valid_i,
  input logic              lreq_ready_o,
  input logic              lrsp_valid_o,
  input logic              lrsp_hit_o,
  input logic              sreq_valid_o,
  input logic [1:0]        sreq_type_o,
  input logic              fwd_valid_i,
  input logic [ADDR_W-1:0] fwd_addr_i,
  input logic              ack_valid_o,
  input logic [ADDR_W-1:0] ack_addr_o
);
  AST_FWD_BLOCKS_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_i |-> !lreq_ready_o); // R9
  AST_FWD_BLOCKS_SREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_i |-> !sreq_valid_o); // R9
  AST_ACK_AFTER_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_i |=> ack_valid_o); // R6
  AST_ACK_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(fwd_valid_i)); // R6
  AST_ACK_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> (ack_addr_o == $past(fwd_addr_i))); // R6
  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrsp_valid_o && lrsp_hit_o) |-> $past(lreq_valid_i && lreq_ready_o)); // R2
  AST_NO_ACCEPT_DURING_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sreq_valid_o && !sreq_type_o[1]) |-> !lreq_ready_o); // R8
endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/msi_line_ctrl_tb_top.sv
module msi_line_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lreq_valid_i = 1'b0;
  logic       lreq_ready_o;
  logic [1:0] lreq_op_i = 2'd0;
  logic [7:0] lreq_addr_i = 8'h00;
  logic       lrsp_valid_o, lrsp_hit_o;
  logic       sreq_valid_o;
  logic       sreq_ready_i = 1'b1;
  logic [1:0] sreq_type_o;
  logic [7:0] sreq_addr_o;
  logic       sgnt_valid_i = 1'b0;
  logic       fwd_valid_i = 1'b0;
  logic [1:0] fwd_type_i = 2'd0;
  logic [7:0] fwd_addr_i = 8'h00;
  logic       ack_valid_o, ack_wb_o;
  logic [7:0] ack_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  msi_line_ctrl #(.NUM_LINES(4), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lreq_valid_i(lreq_valid_i), .lreq_ready_o(lreq_ready_o),
    .lreq_op_i(lreq_op_i), .lreq_addr_i(lreq_addr_i),
    .lrsp_valid_o(lrsp_valid_o), .lrsp_hit_o(lrsp_hit_o),
    .sreq_valid_o(sreq_valid_o), .sreq_ready_i(sreq_ready_i),
    .sreq_type_o(sreq_type_o), .sreq_addr_o(sreq_addr_o),
    .sgnt_valid_i(sgnt_valid_i),
    .fwd_valid_i(fwd_valid_i), .fwd_type_i(fwd_type_i), .fwd_addr_i(fwd_addr_i),
    .ack_valid_o(ack_valid_o), .ack_wb_o(ack_wb_o), .ack_addr_o(ack_addr_o)
  );

  // {op[1:0], addr[7:0], hit, cnt[1:0], type0[1:0], type1[1:0], addr0[7:0]}
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 8'h10, 1'b0, 2'd1, 2'd0, 2'd0, 8'h10}, // R3 load miss GETS
    {2'd0, 8'h10, 1'b1, 2'd0, 2'd0, 2'd0, 8'h00}, // R2 load hit on S
    {2'd1, 8'h10, 1'b0, 2'd1, 2'd1, 2'd0, 8'h10}, // R3 store on S -> GETM
    {2'd1, 8'h10, 1'b1, 2'd0, 2'd0, 2'd0, 8'h00}, // R2 store hit on M
    {2'd0, 8'h10, 1'b1, 2'd0, 2'd0, 2'd0, 8'h00}, // R2 load hit on M
    {2'd0, 8'h20, 1'b0, 2'd2, 2'd2, 2'd0, 8'h10}, // R4 M victim then GETS
    {2'd2, 8'h20, 1'b0, 2'd1, 2'd3, 2'd0, 8'h20}, // R5 evict S -> PUTS
    {2'd2, 8'h20, 1'b0, 2'd0, 2'd0, 2'd0, 8'h00}, // R5 evict absent
    {2'd1, 8'h05, 1'b0, 2'd1, 2'd1, 2'd0, 8'h05}, // R3 store miss from I
    {2'd1, 8'h05, 1'b1, 2'd0, 2'd0, 2'd0, 8'h00}, // R2 store hit
    {2'd2, 8'h05, 1'b0, 2'd1, 2'd2, 2'd0, 8'h05}, // R5 evict M -> PUTM
    {2'd0, 8'h05, 1'b0, 2'd1, 2'd0, 2'd0, 8'h05}  // R5 line now Invalid
  };
  localparam int VREQ [NV] = '{3, 2, 3, 2, 2, 4, 5, 5, 3, 2, 5, 5};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_local(input logic [1:0] op, input logic [7:0] a,
                          output logic hit, output int cnt,
                          output logic [1:0] t0, output logic [1:0] t1,
                          output logic [7:0] a0);
    logic got = 1'b0;
    logic gnt_next = 1'b0;
    hit = 1'b0; cnt = 0; t0 = 2'd0; t1 = 2'd0; a0 = 8'h00;
    @(negedge clk);
    lreq_valid_i = 1'b1; lreq_op_i = op; lreq_addr_i = a;
    for (int c = 0; c < 30 && !got; c++) begin
      @(negedge clk);
      lreq_valid_i = 1'b0;
      sgnt_valid_i = gnt_next;
      gnt_next = 1'b0;
      if (lrsp_valid_o) begin
        got = 1'b1;
        hit = lrsp_hit_o;
      end
      if (sreq_valid_o && sreq_ready_i) begin
        if (cnt == 0) begin t0 = sreq_type_o; a0 = sreq_addr_o; end
        else t1 = sreq_type_o;
        cnt++;
        if (!sreq_type_o[1]) gnt_next = 1'b1;
      end
    end
    sgnt_valid_i = 1'b0;
    if (!got) chk("R8 response missing", 0, 1);
  endtask

  task automatic do_fwd(input logic [1:0] k, input logic [7:0] a, input logic exp_wb,
                        input string req);
    @(negedge clk);
    fwd_valid_i = 1'b1; fwd_type_i = k; fwd_addr_i = a;
    #1 chk("R9 ready during remote", int'(lreq_ready_o), 0);
    @(negedge clk);
    fwd_valid_i = 1'b0;
    chk(req, int'(ack_valid_o), 1);
    chk(req, int'(ack_wb_o), int'(exp_wb));
    chk(req, int'(ack_addr_o), int'(a));
  endtask

  initial begin : watchdog
    #(20ns * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic h; int n; logic [1:0] t0, t1; logic [7:0] a0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", int'(lreq_ready_o), 1);
    chk("R1 rsp", int'(lrsp_valid_o), 0);
    chk("R1 sreq", int'(sreq_valid_o), 0);
    chk("R1 ack", int'(ack_valid_o), 0);

    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VREQ[v], v);
      do_local(VEC[v][24:23], VEC[v][22:15], h, n, t0, t1, a0);
      chk({tg, " hit"}, int'(h), int'(VEC[v][14]));
      chk({tg, " msgs"}, n, int'(VEC[v][13:12]));
      if (VEC[v][13:12] > 0) begin
        chk({tg, " type0"}, int'(t0), int'(VEC[v][11:10]));
        chk({tg, " addr0"}, int'(a0), int'(VEC[v][7:0]));
      end
      if (VEC[v][13:12] > 1) chk({tg, " type1"}, int'(t1), int'(VEC[v][9:8]));
    end

    // R6 read probe on M: write-back, line drops to S
    do_local(2'd1, 8'h10, h, n, t0, t1, a0);
    chk("R3 store miss", int'(t0), 1);
    do_fwd(2'd1, 8'h10, 1'b1, "R6 read probe M");
    do_local(2'd0, 8'h10, h, n, t0, t1, a0);
    chk("R6 S after read probe, load hit", int'(h), 1);
    do_local(2'd1, 8'h10, h, n, t0, t1, a0);
    chk("R6 S after read probe, store upgrade", int'(t0), 1);
    // R6 exclusive probe on M: dirty miss answered with write-back
    do_fwd(2'd2, 8'h10, 1'b1, "R6 exclusive probe M");
    do_local(2'd0, 8'h10, h, n, t0, t1, a0);
    chk("R6 I after exclusive probe", int'(h), 0);
    // R6 invalidate on S
    do_fwd(2'd0, 8'h10, 1'b0, "R6 invalidate S");
    do_local(2'd0, 8'h10, h, n, t0, t1, a0);
    chk("R6 I after invalidate", int'(h), 0);
    // R7 remote event to absent tag on same entry
    do_fwd(2'd2, 8'h30, 1'b0, "R7 absent line");
    do_local(2'd0, 8'h10, h, n, t0, t1, a0);
    chk("R7 line untouched", int'(h), 1);

    // R10 invalidate racing a pending upgrade
    sreq_ready_i = 1'b0;
    @(negedge clk);
    lreq_valid_i = 1'b1; lreq_op_i = 2'd1; lreq_addr_i = 8'h10;
    @(negedge clk);
    lreq_valid_i = 1'b0;
    chk("R3 upgrade presented", int'(sreq_valid_o), 1);
    chk("R3 upgrade type", int'(sreq_type_o), 1);
    fwd_valid_i = 1'b1; fwd_type_i = 2'd0; fwd_addr_i = 8'h10;
    #1 chk("R9 sreq held off", int'(sreq_valid_o), 0);
    @(negedge clk);
    fwd_valid_i = 1'b0;
    chk("R10 ack while pending", int'(ack_valid_o), 1);
    chk("R10 pre-grant state S, no write-back", int'(ack_wb_o), 0);
    sreq_ready_i = 1'b1;
    chk("R8 stall before handshake", int'(lreq_ready_o), 0);
    @(negedge clk);
    chk("R8 stall waiting grant", int'(lreq_ready_o), 0);
    sgnt_valid_i = 1'b1;
    @(negedge clk);
    sgnt_valid_i = 1'b0;
    chk("R3 response after grant", int'(lrsp_valid_o), 1);
    chk("R3 response not hit", int'(lrsp_hit_o), 0);
    do_local(2'd1, 8'h10, h, n, t0, t1, a0);
    chk("R10 grant installed M", int'(h), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule